// File: doc/BRIEF.md
# Parallel ADC Capture Sequencer

This block runs an external parallel analog-to-digital converter with no other clocking help. It drives the converter's conversion clock from its own state machine, spending one cycle with the clock high and one with it low for each sample. The converter's 10-bit output bus is latched on the edge that drops the clock, so every sample costs two cycles of the system clock.

Samples are packed three to a word. The first of the three goes in the upper field, and the finished word leaves on a valid/ready stream that feeds a downstream buffer. If the stream still holds an earlier word when a new one is finished, the block holds the converter clock low and loses no data. It also raises a sticky flag that reports the lost sampling time. When enable is dropped, the block finishes the sample in progress, stops at the next sample boundary and throws away any samples that do not yet fill a word.

Top module: `adc_capture_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `adc_clk`, `out_valid` and `overflow` are all 0.
- R2: While `enable` is low and the block is idle, `adc_clk` stays 0 and no word is offered.
- R3: A sample is one cycle with `adc_clk` high followed by one cycle with it low. The bus value present during the high cycle is captured on the edge that ends it. The first high cycle begins on the edge after `enable` is first seen high.
- R4: While enabled and not stalled, `adc_clk` toggles on every cycle, so there is one sample per two system clock cycles (30 high cycles in any 60).
- R5: A word carries three consecutive samples. The oldest is in bits 29:20, the next in 19:10 and the newest in 9:0. Bits 31:30 are 0.
- R6: A word appears on `out_valid` the cycle after its third capture. `out_data` holds steady while `out_valid` is high and `out_ready` is low.
- R7: If a completed word cannot move because the output still holds an unaccepted word, `adc_clk` is held low until the output frees up, and no sample is lost or duplicated.
- R8: `overflow` goes to 1 the first time such a stall occurs and stays 1 until reset.
- R9: When `enable` is low at a sample boundary, sampling stops and `adc_clk` stays low. Samples that do not make up a full word are discarded, and a word that is already complete is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the sample rate is half of it |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request, checked at each sample boundary |
| adc_data | input | 10 | Parallel data bus from the converter |
| out_ready | input | 1 | Downstream accepts the offered word |
| adc_clk | output | 1 | Conversion clock driven to the converter |
| out_data | output | 32 | Packed word, three samples in bits 29:0 |
| out_valid | output | 1 | A word is offered on `out_data` |
| overflow | output | 1 | Sticky flag: sampling has been paused by back-pressure |

## Verification
Two things can fall in the same cycle: a word finishing its third capture, and the downstream taking the word offered before it. If the block treats that cycle as blocked, it pauses sampling for no reason. If it treats a truly blocked cycle as free, it overwrites a word. A long run with a random `out_ready` (about 70 % high) and fresh random bus data every cycle lands on this collision many times. Every accepted word is compared with the three bus values the bench saw during high `adc_clk` cycles, and a directed hold of `out_ready` low checks that the clock freezes and that `overflow` latches.

// File: rtl/adc_cap_pkg.sv
// Package adc_cap_pkg
// Shared types for the capture sequencer: the sequencing phase of the
// converter clock. Assumes nothing beyond a 2-bit state encoding.
package adc_cap_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HIGH = 2'd1,
        SEQ_LOW  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_clk_seq.sv
// Module adc_clk_seq
// Steps the converter clock through high and low phases, one sample per
// pair. Captures are requested in the high phase. A finished word is pushed
// in the low phase, and the low phase is held while the output cannot take
// it. Assumes word_full rises only from a capture in the high phase.
module adc_clk_seq
    import adc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic word_full,
    input  logic slot_free,
    output logic adc_clk,
    output logic capture_en,
    output logic push,
    output logic discard,
    output logic overflow
);
    seq_state_t state_q, state_d;
    logic       blocked;

    // Decode the current phase into strobes for the packer and output stage.
    always_comb begin
        blocked    = (state_q == SEQ_LOW) && word_full && !slot_free;
        adc_clk    = (state_q == SEQ_HIGH);
        capture_en = (state_q == SEQ_HIGH);
        push       = (state_q == SEQ_LOW) && word_full && slot_free;
        discard    = (state_q == SEQ_LOW) && !blocked && !enable;
    end

    // Next phase: high always falls to low; low repeats, stalls or stops.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: state_d = enable ? SEQ_HIGH : SEQ_IDLE;
            SEQ_HIGH: state_d = SEQ_LOW;
            SEQ_LOW: begin
                if (blocked)     state_d = SEQ_LOW;
                else if (enable) state_d = SEQ_HIGH;
                else             state_d = SEQ_IDLE;
            end
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Sticky overflow: set on any blocked low phase, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       overflow <= 1'b0;
        else if (blocked) overflow <= 1'b1;
    end

    // R3: a high phase always gives way to a low phase.
    a_r3_high_then_low: assert property (@(posedge clk) disable iff (!rst_n)
        adc_clk |=> !adc_clk);

    // R7: a blocked low phase keeps the clock low in the next cycle.
    a_r7_stall_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !adc_clk);

    // R9: with enable low and nothing blocked, the clock stays low.
    a_r9_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_clk && !enable && !blocked) |=> !adc_clk);
endmodule

// File: rtl/sample_packer.sv
// Module sample_packer
// Shifts each captured bus value in from the bottom, so older samples move
// toward the top. After SAMPLES captures it flags a full word. Assumes
// capture and push never coincide and that discard comes only in a low phase.
module sample_packer #(
    parameter int SAMPLE_W = 10,
    parameter int SAMPLES  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         capture_en,
    input  logic                         push,
    input  logic                         discard,
    input  logic [SAMPLE_W-1:0]          sample_in,
    output logic [SAMPLE_W*SAMPLES-1:0]  word,
    output logic                         word_full
);
    localparam int ACC_W = SAMPLE_W * SAMPLES;
    localparam int CNT_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;

    // Shift register: new sample enters the low field.
    generate
        if (SAMPLES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n)          acc_q <= '0;
                else if (capture_en) acc_q <= {acc_q[ACC_W-SAMPLE_W-1:0], sample_in};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n)          acc_q <= '0;
                else if (capture_en) acc_q <= sample_in;
            end
        end
    endgenerate

    // Sample counter and full flag; a discard restarts the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            word_full <= 1'b0;
        end else if (capture_en) begin
            if (cnt_q == LAST) begin
                cnt_q     <= '0;
                word_full <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (push)    word_full <= 1'b0;
            if (discard) cnt_q     <= '0;
        end
    end

    assign word = acc_q;

    // R7: a waiting full word is never shifted over by a new capture.
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        word_full |-> !capture_en);

    // R5: the counter stays within one word.
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R9: after a discard, the next word starts from an empty count.
    a_r9_discard_clears: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> (cnt_q == '0));
endmodule

// File: rtl/out_stage.sv
// Module out_stage
// One-entry valid/ready output register. A push loads the packed word,
// zero-extended to the stream width. Assumes push only when slot_free is high.
module out_stage #(
    parameter int ACC_W  = 30,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ACC_W-1:0]  word,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              slot_free
);
    // The slot is usable if empty or being emptied this cycle.
    assign slot_free = !out_valid || out_ready;

    // Output register with handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (push) begin
            out_valid <= 1'b1;
            out_data  <= WORD_W'(word);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R6: an unaccepted word stays offered and unchanged.
    a_r6_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    generate
        if (WORD_W > ACC_W) begin : g_pad
            // R5: padding bits above the packed samples read zero.
            a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_data[WORD_W-1:ACC_W] == '0));
        end
    endgenerate
endmodule

// File: rtl/adc_capture_seq.sv
// Module adc_capture_seq (top)
// Drives the conversion clock of a parallel ADC, captures its bus once per
// clock pair, packs SAMPLES values per word and offers the words on a
// valid/ready stream. Assumes the converter output is valid during the high
// phase and that all inputs are synchronous to clk.
module adc_capture_seq #(
    parameter int SAMPLE_W = 10,
    parameter int SAMPLES  = 3,
    parameter int WORD_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [SAMPLE_W-1:0] adc_data,
    input  logic                out_ready,
    output logic                adc_clk,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_valid,
    output logic                overflow
);
    localparam int ACC_W = SAMPLE_W * SAMPLES;

    logic             capture_en;
    logic             push;
    logic             discard;
    logic             word_full;
    logic             slot_free;
    logic [ACC_W-1:0] word;

    adc_clk_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .word_full  (word_full),
        .slot_free  (slot_free),
        .adc_clk    (adc_clk),
        .capture_en (capture_en),
        .push       (push),
        .discard    (discard),
        .overflow   (overflow)
    );

    sample_packer #(
        .SAMPLE_W (SAMPLE_W),
        .SAMPLES  (SAMPLES)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .push       (push),
        .discard    (discard),
        .sample_in  (adc_data),
        .word       (word),
        .word_full  (word_full)
    );

    out_stage #(
        .ACC_W  (ACC_W),
        .WORD_W (WORD_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .word      (word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .slot_free (slot_free)
    );

    // R8: once set, the overflow flag stays set.
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: the flag rises only while an earlier word is being held back.
    a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(out_valid && !out_ready));

    // R7: a full word waiting behind an unaccepted one keeps the clock low.
    a_r7_clock_low_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (word_full && out_valid && !out_ready) |-> !adc_clk);
endmodule

// File: tb/sim_adc_capture_seq.sv
`timescale 1ns/1ps
module sim_adc_capture_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [9:0]  adc_data = '0;
    logic        out_ready = 1'b0;
    logic        adc_clk;
    logic [31:0] out_data;
    logic        out_valid;
    logic        overflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic        en_v = 1'b0;
    logic        rdy_v = 1'b0;
    logic [9:0]  seen[$];
    int          highs;

    adc_capture_seq u0 (
        .clk (clk), .rst_n (rst_n), .enable (enable), .adc_data (adc_data),
        .out_ready (out_ready), .adc_clk (adc_clk), .out_data (out_data),
        .out_valid (out_valid), .overflow (overflow)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pack3(logic [9:0] a, logic [9:0] b, logic [9:0] c);
        return {2'b00, a, b, c};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, observe 1 ns later (well before posedge).
    task automatic step();
        logic [31:0] exp;
        @(negedge clk);
        enable    = en_v;
        out_ready = rdy_v;
        adc_data  = 10'($urandom);
        #1;
        if (!rst_n) return;
        if (adc_clk) seen.push_back(adc_data);
        if (out_valid && out_ready) begin
            if (seen.size() < 3) begin
                check(1'b0, "R5 word without three samples", out_data, 32'(seen.size()));
            end else begin
                exp = pack3(seen[0], seen[1], seen[2]);
                check(out_data == exp, "R5/R6 packed word", out_data, exp);
                void'(seen.pop_front()); void'(seen.pop_front()); void'(seen.pop_front());
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL R4 watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2718));
        // R1: reset state
        repeat (4) step();
        check(adc_clk == 0 && out_valid == 0 && overflow == 0, "R1 reset outputs",
              {29'd0, adc_clk, out_valid, overflow}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(adc_clk == 0 && out_valid == 0 && overflow == 0, "R1 after release",
              {29'd0, adc_clk, out_valid, overflow}, 32'd0);

        // R2: idle with enable low
        rdy_v = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            check(adc_clk == 0 && out_valid == 0, "R2 idle quiet",
                  {30'd0, adc_clk, out_valid}, 32'd0);
        end

        // R3: first high cycle follows the first enable
        en_v = 1'b1;
        step();
        check(adc_clk == 0, "R3 not high in enable cycle", 32'(adc_clk), 32'd0);
        step();
        check(adc_clk == 1, "R3 high one cycle after enable", 32'(adc_clk), 32'd1);
        step();
        check(adc_clk == 0, "R3 low after high", 32'(adc_clk), 32'd0);

        // R4: continuous rate
        repeat (7) step();
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (adc_clk) highs++;
        end
        check(highs == 30, "R4 high cycles in 60", 32'(highs), 32'd30);
        check(overflow == 0, "R8 no overflow before any stall", 32'(overflow), 32'd0);

        // R7/R8: directed stall
        rdy_v = 1'b0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (i == 20) held = out_data;
            if (i >= 20) begin
                check(adc_clk == 0, "R7 clock held low in stall", 32'(adc_clk), 32'd0);
                check(out_valid == 1 && out_data == held, "R6 word held", out_data, held);
            end
        end
        check(overflow == 1, "R8 overflow set by stall", 32'(overflow), 32'd1);
        rdy_v = 1'b1;
        repeat (30) step();
        check(overflow == 1, "R8 overflow sticky", 32'(overflow), 32'd1);

        // R9: stop at boundary, discard partial word
        for (int t = 0; t < 24; t++) begin
            en_v = 1'b1;
            repeat (1 + ($urandom % 14)) step();
            en_v = 1'b0;
            for (int i = 0; i < 8; i++) begin
                step();
                if (i >= 4) check(adc_clk == 0, "R9 clock stays low after stop",
                                  32'(adc_clk), 32'd0);
            end
            check(seen.size() < 3, "R9 completed words delivered", 32'(seen.size()), 32'd2);
            seen.delete();
        end

        // R5/R6/R7: random back-pressure with enable held
        en_v = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            rdy_v = (($urandom % 10) < 7);
            step();
        end
        rdy_v = 1'b1;
        en_v  = 1'b0;
        repeat (10) step();
        check(seen.size() < 3, "R7 no sample lost under back-pressure",
              32'(seen.size()), 32'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule